// File: doc/BRIEF.md
# Debug Halt Request Controller

This block decides when a processor core must stop for background debug and when it may run again. It watches four kinds of halt source: a fault-on-fault condition, a bank of hardware breakpoint triggers, an external breakpoint pin, and the decode of a HALT instruction. When several sources are active in the same cycle, a fixed priority picks one of them. The block then reports that the core is halted and gives a code for the source that caused the halt.

Breakpoint requests do not stop the core at once. They are caught in a pending latch, and the halt is taken only on a cycle where the instruction-boundary strobe is high. A HALT instruction stops the core at once. In user mode, however, it is allowed only if the user-halt-enable control bit is set. If that bit is clear, the block raises a privilege-violation exception request and the core does not halt.

A GO command from the debug interface releases a halted core. The block also answers debug commands. Register-access commands are granted only while the core is halted; while it runs, they get a not-ready response. Memory-access commands are granted in either state. All outputs are registered, so each response appears one clock after the input that causes it.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `halted_o`, `pend_o`, `priv_viol_o`, `reg_ack_o`, `reg_nrdy_o` and `mem_ack_o` are 0 and `cause_o` is 0. The cause codes are: 0 none, 1 fault-on-fault, 2 breakpoint, 3 HALT instruction.
- R2: If `fof_i` is high while the core runs, the next cycle shows `halted_o`=1 and `cause_o`=1, whatever the other sources do.
- R3: A breakpoint is any bit of `bkpt_trig_i` high, or `bkpt_pin_i` high. A breakpoint while the core runs, in a cycle with no halt taken, sets `pend_o` in the next cycle. The core does not halt until an instruction boundary.
- R4: On a running cycle with `insn_bound_i`=1, no fault-on-fault, and a pending or present breakpoint, the next cycle shows `halted_o`=1, `cause_o`=2 and `pend_o`=0. This outranks a HALT instruction in the same cycle.
- R5: If `halt_insn_i` is high while the core runs, there is no higher source, and either `user_mode_i`=0 or `user_halt_en_i`=1, the next cycle shows `halted_o`=1, `cause_o`=3 and `pend_o`=0.
- R6: If `halt_insn_i` is high with `user_mode_i`=1 and `user_halt_en_i`=0, and there is no higher source, the next cycle shows a one-cycle `priv_viol_o` pulse. The core stays running and the pending latch is kept.
- R7: `go_i` while halted returns the core to running in the next cycle, with `cause_o`=0. `go_i` while running has no effect on any output.
- R8: While halted, all halt sources are ignored: `cause_o` keeps its value, `pend_o` stays 0 and `priv_viol_o` stays 0.
- R9: `reg_cmd_i` produces a one-cycle `reg_ack_o` pulse in the next cycle if `halted_o` was 1 in the command cycle. Otherwise it produces a one-cycle `reg_nrdy_o` pulse.
- R10: `mem_cmd_i` produces a one-cycle `mem_ack_o` pulse in the next cycle, whether the core is halted or running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fof_i | input | 1 | Fault-on-fault condition |
| bkpt_trig_i | input | NUM_BKPT | Hardware breakpoint triggers |
| bkpt_pin_i | input | 1 | External breakpoint pin |
| insn_bound_i | input | 1 | Instruction-boundary sample strobe |
| halt_insn_i | input | 1 | HALT instruction decode strobe |
| user_mode_i | input | 1 | Core is in user mode |
| user_halt_en_i | input | 1 | Permits HALT in user mode |
| go_i | input | 1 | GO command from the debug interface |
| reg_cmd_i | input | 1 | Register-access command |
| mem_cmd_i | input | 1 | Memory-access command |
| halted_o | output | 1 | Core is halted |
| cause_o | output | 2 | Halt cause code |
| pend_o | output | 1 | Breakpoint halt is pending |
| priv_viol_o | output | 1 | Privilege-violation exception request |
| reg_ack_o | output | 1 | Register command granted |
| reg_nrdy_o | output | 1 | Register command rejected, not ready |
| mem_ack_o | output | 1 | Memory command granted |

## Verification
Two things can happen in the same cycle: an instruction boundary that takes a pending breakpoint halt, and a HALT instruction decode. The fault-on-fault input can join them as well. The bench sweeps every combination of the halt inputs, both with and without a breakpoint latched beforehand, and checks the one winner that the priority order predicts. A second collision is a GO command that arrives together with a register command. The register command must be judged on the halted state of its own cycle, so it is granted even though the core is running one cycle later.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int CAUSE_W = 2;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_FOF  = 2'd1,
    CAUSE_BKPT = 2'd2,
    CAUSE_HALT = 2'd3
  } halt_cause_e;

  typedef struct packed {
    logic        take;
    halt_cause_e cause;
    logic        priv_viol;
  } halt_dec_t;
endpackage

// File: rtl/dbg_halt_pend.sv
module dbg_halt_pend #(
  parameter int NUM_BKPT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_BKPT-1:0] bkpt_trig_i,
  input  logic                bkpt_pin_i,
  input  logic                halted_i,
  input  logic                take_i,
  output logic                bkpt_now_o,
  output logic                pend_o
);
  logic pend_q;

  assign bkpt_now_o = (|bkpt_trig_i) | bkpt_pin_i;
  assign pend_o     = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (take_i || halted_i) begin
      pend_q <= 1'b0;
    end else if (bkpt_now_o) begin
      pend_q <= 1'b1;
    end
  end

  // R8
  pend_idle_when_halted_chk: assert property (@(posedge clk) disable iff (rst)
    halted_i |=> !pend_q);
  // R3
  pend_catch_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted_i && !take_i && bkpt_now_o) |=> pend_q);
endmodule

// File: rtl/dbg_halt_arb.sv
module dbg_halt_arb
  import dbg_halt_pkg::*;
(
  input  logic      halted_i,
  input  logic      fof_i,
  input  logic      bkpt_now_i,
  input  logic      pend_i,
  input  logic      insn_bound_i,
  input  logic      halt_insn_i,
  input  logic      user_mode_i,
  input  logic      user_halt_en_i,
  output halt_dec_t dec_o
);
  logic bkpt_ready;
  logic halt_denied;

  assign bkpt_ready  = insn_bound_i && (pend_i || bkpt_now_i);
  assign halt_denied = user_mode_i && !user_halt_en_i;

  always_comb begin
    dec_o = '{take: 1'b0, cause: CAUSE_NONE, priv_viol: 1'b0};
    if (!halted_i) begin
      if (fof_i) begin
        dec_o.take  = 1'b1;
        dec_o.cause = CAUSE_FOF;
      end else if (bkpt_ready) begin
        dec_o.take  = 1'b1;
        dec_o.cause = CAUSE_BKPT;
      end else if (halt_insn_i) begin
        if (halt_denied) begin
          dec_o.priv_viol = 1'b1;
        end else begin
          dec_o.take  = 1'b1;
          dec_o.cause = CAUSE_HALT;
        end
      end
    end
  end
endmodule

// File: rtl/dbg_cmd_gate.sv
module dbg_cmd_gate (
  input  logic clk,
  input  logic rst,
  input  logic halted_i,
  input  logic reg_cmd_i,
  input  logic mem_cmd_i,
  output logic reg_ack_o,
  output logic reg_nrdy_o,
  output logic mem_ack_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_ack_o  <= 1'b0;
      reg_nrdy_o <= 1'b0;
      mem_ack_o  <= 1'b0;
    end else begin
      reg_ack_o  <= reg_cmd_i && halted_i;
      reg_nrdy_o <= reg_cmd_i && !halted_i;
      mem_ack_o  <= mem_cmd_i;
    end
  end

  // R9
  reg_reject_running_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_cmd_i && !halted_i) |=> (reg_nrdy_o && !reg_ack_o));
  // R9
  reg_grant_halted_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_cmd_i && halted_i) |=> (reg_ack_o && !reg_nrdy_o));
  // R10
  mem_grant_chk: assert property (@(posedge clk) disable iff (rst)
    mem_cmd_i |=> mem_ack_o);
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int NUM_BKPT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fof_i,
  input  logic [NUM_BKPT-1:0] bkpt_trig_i,
  input  logic                bkpt_pin_i,
  input  logic                insn_bound_i,
  input  logic                halt_insn_i,
  input  logic                user_mode_i,
  input  logic                user_halt_en_i,
  input  logic                go_i,
  input  logic                reg_cmd_i,
  input  logic                mem_cmd_i,
  output logic                halted_o,
  output logic [CAUSE_W-1:0]  cause_o,
  output logic                pend_o,
  output logic                priv_viol_o,
  output logic                reg_ack_o,
  output logic                reg_nrdy_o,
  output logic                mem_ack_o
);
  logic        halted_q;
  halt_cause_e cause_q;
  logic        priv_q;
  logic        bkpt_now;
  logic        pend;
  halt_dec_t   dec;

  dbg_halt_pend #(.NUM_BKPT(NUM_BKPT)) u_pend (
    .clk         (clk),
    .rst         (rst),
    .bkpt_trig_i (bkpt_trig_i),
    .bkpt_pin_i  (bkpt_pin_i),
    .halted_i    (halted_q),
    .take_i      (dec.take),
    .bkpt_now_o  (bkpt_now),
    .pend_o      (pend)
  );

  dbg_halt_arb u_arb (
    .halted_i       (halted_q),
    .fof_i          (fof_i),
    .bkpt_now_i     (bkpt_now),
    .pend_i         (pend),
    .insn_bound_i   (insn_bound_i),
    .halt_insn_i    (halt_insn_i),
    .user_mode_i    (user_mode_i),
    .user_halt_en_i (user_halt_en_i),
    .dec_o          (dec)
  );

  dbg_cmd_gate u_cmd (
    .clk        (clk),
    .rst        (rst),
    .halted_i   (halted_q),
    .reg_cmd_i  (reg_cmd_i),
    .mem_cmd_i  (mem_cmd_i),
    .reg_ack_o  (reg_ack_o),
    .reg_nrdy_o (reg_nrdy_o),
    .mem_ack_o  (mem_ack_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
      cause_q  <= CAUSE_NONE;
      priv_q   <= 1'b0;
    end else begin
      priv_q <= dec.priv_viol;
      if (halted_q) begin
        if (go_i) begin
          halted_q <= 1'b0;
          cause_q  <= CAUSE_NONE;
        end
      end else if (dec.take) begin
        halted_q <= 1'b1;
        cause_q  <= dec.cause;
      end
    end
  end

  assign halted_o    = halted_q;
  assign cause_o     = cause_q;
  assign pend_o      = pend;
  assign priv_viol_o = priv_q;

  // R2
  fof_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted_q && fof_i) |=> (halted_q && cause_q == CAUSE_FOF));
  // R7
  go_release_chk: assert property (@(posedge clk) disable iff (rst)
    (halted_q && go_i) |=> (!halted_q && cause_q == CAUSE_NONE));
  // R6
  priv_no_halt_chk: assert property (@(posedge clk) disable iff (rst)
    priv_q |-> !halted_q);
  // R8
  cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (halted_q && !go_i) |=> (halted_q && $stable(cause_q)));
  // R4
  halt_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(halted_q) |-> (cause_q != CAUSE_NONE));
endmodule

// File: tb/tb_dbg_halt_ctrl.sv
module tb_dbg_halt_ctrl;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fof = 0, pin = 0, bnd = 0, hlt = 0, usr = 0, uhe = 0;
  logic go = 0, rcmd = 0, mcmd = 0;
  logic [NB-1:0] trig = '0;
  logic halted, pend, priv, rack, rnrdy, mack;
  logic [1:0] cause;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dbg_halt_ctrl #(.NUM_BKPT(NB)) dut (
    .clk(clk), .rst(rst), .fof_i(fof), .bkpt_trig_i(trig), .bkpt_pin_i(pin),
    .insn_bound_i(bnd), .halt_insn_i(hlt), .user_mode_i(usr),
    .user_halt_en_i(uhe), .go_i(go), .reg_cmd_i(rcmd), .mem_cmd_i(mcmd),
    .halted_o(halted), .cause_o(cause), .pend_o(pend), .priv_viol_o(priv),
    .reg_ack_o(rack), .reg_nrdy_o(rnrdy), .mem_ack_o(mack)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    fof = 0; pin = 0; bnd = 0; hlt = 0; usr = 0; uhe = 0;
    go = 0; rcmd = 0; mcmd = 0; trig = '0;
  endtask

  // one clock: inputs already set after a negedge, sample at following negedge
  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [7:0] obs();
    return {1'b0, mack, rnrdy, rack, priv, pend, cause, halted} & 8'hFF;
  endfunction

  task automatic do_reset();
    clear_in();
    rst = 1;
    tick(); tick();
    rst = 0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: first cycle after reset
    chk("R1", {halted, pend, priv, rack, rnrdy, mack, cause}, 8'h00);

    // Sweep: 2 pending states x 128 input combinations
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 128; c++) begin
        logic bk, e_h, e_pr, e_pd;
        logic [1:0] e_c;
        string req;
        do_reset();
        if (p == 1) begin
          trig = NB'(1) << (c % NB);
          tick();
          clear_in();
          chk("R3", {7'd0, pend}, 8'd1);
          chk("R3", {7'd0, halted}, 8'd0);
        end
        fof = c[0]; trig = c[1] ? (NB'(1) << ((c >> 2) % NB)) : '0;
        pin = c[2]; bnd = c[3]; hlt = c[4]; usr = c[5]; uhe = c[6];
        bk = c[1] | c[2];
        e_h = 0; e_c = 0; e_pr = 0; e_pd = (p == 1) | bk; req = "R3";
        if (c[0]) begin
          e_h = 1; e_c = 1; e_pd = 0; req = "R2";
        end else if (c[3] && ((p == 1) || bk)) begin
          e_h = 1; e_c = 2; e_pd = 0; req = "R4";
        end else if (c[4]) begin
          if (c[5] && !c[6]) begin
            e_pr = 1; req = "R6";
          end else begin
            e_h = 1; e_c = 3; e_pd = 0; req = "R5";
          end
        end
        tick();
        clear_in();
        chk(req, {3'd0, priv, pend, cause, halted}, {3'd0, e_pr, e_pd, e_c, e_h});
        if (req == "R6") begin
          tick();
          chk("R6", {7'd0, priv}, 8'd0);
        end
      end
    end

    // Halted behaviour: halt via HALT instruction (supervisor)
    do_reset();
    hlt = 1; tick(); clear_in();
    chk("R5", {6'd0, cause}, 8'd3);
    // R8: all sources while halted are ignored
    fof = 1; trig = '1; pin = 1; bnd = 1; hlt = 1; usr = 1; uhe = 0;
    tick(); clear_in();
    chk("R8", {3'd0, priv, pend, cause, halted}, {3'd0, 1'b0, 1'b0, 2'd3, 1'b1});
    // R9: register command while halted is granted
    rcmd = 1; tick(); clear_in();
    chk("R9", {6'd0, rack, rnrdy}, 8'b10);
    // R10: memory command while halted
    mcmd = 1; tick(); clear_in();
    chk("R10", {7'd0, mack}, 8'd1);
    tick();
    chk("R10", {7'd0, mack}, 8'd0);
    // R7 + R9: GO together with register command
    go = 1; rcmd = 1; tick(); clear_in();
    chk("R7", {5'd0, cause, halted}, 8'd0);
    chk("R9", {6'd0, rack, rnrdy}, 8'b10);
    // R9: register command while running rejected
    rcmd = 1; tick(); clear_in();
    chk("R9", {6'd0, rack, rnrdy}, 8'b01);
    tick();
    chk("R9", {6'd0, rack, rnrdy}, 8'b00);
    // R10: memory command while running
    mcmd = 1; tick(); clear_in();
    chk("R10", {7'd0, mack}, 8'd1);
    // R7: GO while running has no effect
    go = 1; tick(); clear_in();
    chk("R7", obs(), 8'd0);
    // R2: fault-on-fault halts, then GO, then breakpoint pin pending then boundary
    fof = 1; tick(); clear_in();
    chk("R2", {5'd0, cause, halted}, {5'd0, 2'd1, 1'b1});
    go = 1; tick(); clear_in();
    chk("R7", {5'd0, cause, halted}, 8'd0);
    pin = 1; tick(); clear_in();
    tick(); tick();
    chk("R3", {6'd0, pend, halted}, 8'b10);
    bnd = 1; tick(); clear_in();
    chk("R4", {5'd0, pend, cause, halted}, {5'd0, 1'b0, 2'd2, 1'b1});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule